// File: doc/BRIEF.md
# Teletext Page Request Matcher with Control-Row Capture

The block keeps a small table of page requests, one entry for each of eight page slots arranged as two groups of four. Each entry is seven 5-bit columns that describe the wanted magazine, page number and time sub-code digit by digit. Every column carries a do-care flag, so any digit can be wildcarded. Software fills the table through a write pointer: it loads a slot and a start column, then sends data words, and the column steps forward by itself after each word.

When a page header arrives, already Hamming-decoded into nibbles with one error flag per nibble, the block walks through the seven request columns at one column per clock. It compares all four slots of the acquisition group in parallel. A slot whose entry is held, or whose cared-about digits disagree or carry an error, drops out. If any slot survives, the lowest-numbered one wins. The block then gives a one-cycle match pulse and streams a ten-byte control-data record for that slot. A downstream page memory writes the record into the slot's control row.

Top module: `page_req_match`

## Requirements
- R1: After reset the block is idle (busy, match and the record write strobe low), and every request entry reads as zero. An entry of zero is held, so no header can match until the table is written.
- R2: A load pulse sets the write slot (3 bits: group in bit 2, page in bits 1:0) and the start column. Each data write stores the word in the current column and then advances the column by one. A write at column 7 stores nothing, and the column then wraps to 0.
- R3: Column order is magazine, page tens, page units, hours tens, hours units, minutes tens, minutes units. Bit 4 of a column is its do-care flag. Compared widths are 3, 4, 4, 2, 4, 3 and 4 bits, taken from the low bits of the column. A digit whose do-care flag is 0 never affects the result.
- R4: Bit 3 of column 0 is the hold flag. When it is 0 the slot never matches.
- R5: A cared-about digit whose header error flag is set prevents the match. An error flag on a digit that is not cared about has no effect.
- R6: Only the four slots of the group named by the group input, sampled with the header, take part. The reported slot is {group, page}.
- R7: The match pulse lasts one cycle and rises exactly eight clock edges after the edge that accepts the header. Headers presented while busy are ignored.
- R8: When several slots of the group match, the lowest page index wins.
- R9: On a match, the record write strobe is high for ten consecutive cycles, starting in the cycle of the match pulse. The byte index runs 0 to 9 and the slot stays equal to the matched slot.
- R10: Record bytes 0 to 7 carry the header nibbles in the order: page units, page tens, minutes units, minutes tens with C4 in bit 3, hours units, hours tens with C5/C6 in bits 2/3, C7–C10, C11–C14. The nibble sits in bits 3:0, its error flag in bit 4, and bits 7:5 are zero.
- R11: Record byte 8 holds the magazine in bits 2:0, with the found flag in bit 4 written low (found) and all other bits zero. Byte 9 is all zero, with the page-being-looked-for flag (bit 5) cleared.
- R12: When no slot matches, no record is written and busy falls right after the decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ptr_load | input | 1 | Load write slot and start column |
| req_ptr_slot | input | 3 | Slot for request writes |
| req_ptr_col | input | 3 | Start column for request writes |
| req_wr_en | input | 1 | Write one request column and advance |
| req_wr_data | input | 5 | Request column word |
| acq_group | input | 1 | Group used for the next header |
| hdr_valid | input | 1 | Header present (one cycle) |
| hdr_mag | input | 3 | Decoded magazine |
| hdr_mag_err | input | 1 | Magazine decode error |
| hdr_nibs | input | 32 | Decoded header nibbles 0..7, nibble k in bits 4k+3:4k |
| hdr_errs | input | 8 | Error flag per header nibble |
| busy | output | 1 | Comparison or record output in progress |
| match | output | 1 | One-cycle match pulse |
| match_slot | output | 3 | Matched slot {group, page} |
| r25_we | output | 1 | Control-record byte write strobe |
| r25_slot | output | 3 | Slot the record belongs to |
| r25_col | output | 4 | Record byte index 0..9 |
| r25_data | output | 8 | Record byte |

## Verification
Directed headers first isolate single effects. One header differs from a request only in a cared digit, another only in an uncared digit, and others carry an error flag on a cared or an uncared digit. Further headers target a held slot, the other group, two matching slots and a header sent while busy. Constrained-random runs then rewrite random slots with random do-care masks and send headers copied from a chosen request, with random perturbation and error flags. These runs separate the masking widths, the hold flag and the priority order from plain equality. Every match is followed byte by byte through the record, which shows whether the nibble order, the error flags and the found and looked-for bits are formatted correctly.

// File: rtl/pgreq_pkg.sv
package pgreq_pkg;
  localparam int COLS      = 7;
  localparam int COL_W     = 5;
  localparam int HDR_NIBS  = 8;
  localparam int R25_BYTES = 10;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_DECIDE, S_WRITE} seq_state_t;

  // compared bits of each request column
  function automatic logic [3:0] digit_mask(input logic [2:0] col);
    case (col)
      3'd0, 3'd5: digit_mask = 4'h7;
      3'd3:       digit_mask = 4'h3;
      3'd7:       digit_mask = 4'h0;
      default:    digit_mask = 4'hF;
    endcase
  endfunction

  // header digit that a request column is compared against
  function automatic logic [3:0] hdr_digit(input logic [2:0] col, input logic [2:0] mag,
                                           input logic [31:0] nibs);
    case (col)
      3'd0:    hdr_digit = {1'b0, mag};
      3'd1:    hdr_digit = nibs[7:4];
      3'd2:    hdr_digit = nibs[3:0];
      3'd3:    hdr_digit = nibs[23:20];
      3'd4:    hdr_digit = nibs[19:16];
      3'd5:    hdr_digit = nibs[15:12];
      3'd6:    hdr_digit = nibs[11:8];
      default: hdr_digit = 4'h0;
    endcase
  endfunction

  function automatic logic hdr_error(input logic [2:0] col, input logic mag_err,
                                     input logic [7:0] errs);
    case (col)
      3'd0:    hdr_error = mag_err;
      3'd1:    hdr_error = errs[1];
      3'd2:    hdr_error = errs[0];
      3'd3:    hdr_error = errs[5];
      3'd4:    hdr_error = errs[4];
      3'd5:    hdr_error = errs[3];
      3'd6:    hdr_error = errs[2];
      default: hdr_error = 1'b0;
    endcase
  endfunction

  // control-record byte formatting
  function automatic logic [7:0] r25_byte(input logic [3:0] idx, input logic [31:0] nibs,
                                          input logic [7:0] errs, input logic [2:0] mag);
    if (idx < 4'd8)
      r25_byte = {3'b000, errs[idx[2:0]], nibs[{idx[2:0], 2'b00} +: 4]};
    else if (idx == 4'd8)
      r25_byte = {3'b000, 1'b0, 1'b0, mag};
    else
      r25_byte = 8'h00;
  endfunction
endpackage

// File: rtl/pgreq_store.sv
module pgreq_store
  import pgreq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int NCOL  = COLS,
  parameter int CW    = COL_W,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ptr_load,
  input  logic [SW-1:0]                        ptr_slot,
  input  logic [2:0]                           ptr_col,
  input  logic                                 wr_en,
  input  logic [CW-1:0]                        wr_data,
  output logic [SLOTS-1:0][NCOL-1:0][CW-1:0]   req_q,
  output logic                                 wr_commit
);
  logic [SW-1:0] slot_q;
  logic [2:0]    col_q;

  assign wr_commit = wr_en && !ptr_load && (int'(col_q) < NCOL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      slot_q <= '0;
      col_q  <= '0;
    end else if (ptr_load) begin
      slot_q <= ptr_slot;
      col_q  <= ptr_col;
    end else if (wr_en) begin
      if (wr_commit) req_q[slot_q][col_q] <= wr_data;
      col_q <= col_q + 3'd1;
    end
  end
endmodule

// File: rtl/pgreq_cmp.sv
module pgreq_cmp
  import pgreq_pkg::*;
#(
  parameter int PAGES = 4,
  parameter int NCOL  = COLS,
  parameter int CW    = COL_W
) (
  input  logic [PAGES-1:0][NCOL-1:0][CW-1:0] grp_req,
  input  logic [2:0]                         col,
  input  logic [3:0]                         dig,
  input  logic                               dig_err,
  output logic [PAGES-1:0]                   miss,
  output logic [PAGES-1:0]                   held
);
  logic [3:0] mask;
  assign mask = digit_mask(col);

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    logic [CW-1:0] entry;
    assign entry   = grp_req[p][col];
    assign miss[p] = entry[CW-1] && (dig_err || (((entry[3:0] ^ dig) & mask) != 4'h0));
    assign held[p] = !grp_req[p][0][3];
  end
endmodule

// File: rtl/pgreq_seq.sv
module pgreq_seq
  import pgreq_pkg::*;
#(
  parameter int PAGES  = 4,
  parameter int GROUPS = 2,
  localparam int PW    = $clog2(PAGES),
  localparam int GW    = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [GW-1:0]     hdr_group,
  input  logic [2:0]        hdr_mag,
  input  logic              hdr_mag_err,
  input  logic [31:0]       hdr_nibs,
  input  logic [7:0]        hdr_errs,
  input  logic [PAGES-1:0]  miss,
  input  logic [PAGES-1:0]  held,
  output logic [2:0]        cur_col,
  output logic [3:0]        cur_dig,
  output logic              cur_err,
  output logic [GW-1:0]     grp_q,
  output logic              hdr_take,
  output logic              busy,
  output logic              match,
  output logic [GW+PW-1:0]  match_slot,
  output logic              r25_we,
  output logic [GW+PW-1:0]  r25_slot,
  output logic [3:0]        r25_col,
  output logic [7:0]        r25_data
);
  seq_state_t        state_q;
  logic [3:0]        cnt_q;
  logic [PAGES-1:0]  alive_q;
  logic [PAGES-1:0]  hits;
  logic [PW-1:0]     win_q;
  logic [2:0]        mag_q;
  logic              mag_err_q;
  logic [31:0]       nibs_q;
  logic [7:0]        errs_q;

  function automatic logic [PW-1:0] first_hit(input logic [PAGES-1:0] v);
    first_hit = '0;
    for (int i = PAGES - 1; i >= 0; i--)
      if (v[i]) first_hit = PW'(i);
  endfunction

  assign hdr_take = hdr_valid && (state_q == S_IDLE);
  assign cur_col  = cnt_q[2:0];
  assign cur_dig  = hdr_digit(cur_col, mag_q, nibs_q);
  assign cur_err  = hdr_error(cur_col, mag_err_q, errs_q);
  assign hits     = alive_q & ~held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      alive_q   <= '0;
      win_q     <= '0;
      grp_q     <= '0;
      mag_q     <= '0;
      mag_err_q <= 1'b0;
      nibs_q    <= '0;
      errs_q    <= '0;
      match     <= 1'b0;
    end else begin
      match <= 1'b0;
      case (state_q)
        S_IDLE: if (hdr_valid) begin
          grp_q     <= hdr_group;
          mag_q     <= hdr_mag;
          mag_err_q <= hdr_mag_err;
          nibs_q    <= hdr_nibs;
          errs_q    <= hdr_errs;
          alive_q   <= '1;
          cnt_q     <= '0;
          state_q   <= S_CMP;
        end
        S_CMP: begin
          alive_q <= alive_q & ~miss;
          cnt_q   <= cnt_q + 4'd1;
          if (int'(cnt_q) == COLS - 1) state_q <= S_DECIDE;
        end
        S_DECIDE: begin
          cnt_q <= '0;
          if (|hits) begin
            match   <= 1'b1;
            win_q   <= first_hit(hits);
            state_q <= S_WRITE;
          end else begin
            state_q <= S_IDLE;
          end
        end
        default: begin
          cnt_q <= cnt_q + 4'd1;
          if (int'(cnt_q) == R25_BYTES - 1) state_q <= S_IDLE;
        end
      endcase
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign match_slot = {grp_q, win_q};
  assign r25_we     = (state_q == S_WRITE);
  assign r25_slot   = {grp_q, win_q};
  assign r25_col    = cnt_q;
  assign r25_data   = r25_byte(cnt_q, nibs_q, errs_q, mag_q);
endmodule

// File: rtl/page_req_match.sv
module page_req_match
  import pgreq_pkg::*;
#(
  parameter int PAGES  = 4,
  parameter int GROUPS = 2,
  localparam int PW    = $clog2(PAGES),
  localparam int GW    = $clog2(GROUPS),
  localparam int SLOTS = PAGES * GROUPS,
  localparam int SW    = PW + GW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_ptr_load,
  input  logic [SW-1:0]     req_ptr_slot,
  input  logic [2:0]        req_ptr_col,
  input  logic              req_wr_en,
  input  logic [COL_W-1:0]  req_wr_data,
  input  logic [GW-1:0]     acq_group,
  input  logic              hdr_valid,
  input  logic [2:0]        hdr_mag,
  input  logic              hdr_mag_err,
  input  logic [31:0]       hdr_nibs,
  input  logic [7:0]        hdr_errs,
  output logic              busy,
  output logic              match,
  output logic [SW-1:0]     match_slot,
  output logic              r25_we,
  output logic [SW-1:0]     r25_slot,
  output logic [3:0]        r25_col,
  output logic [7:0]        r25_data
);
  logic [SLOTS-1:0][COLS-1:0][COL_W-1:0] req_q;
  logic [PAGES-1:0][COLS-1:0][COL_W-1:0] grp_req;
  logic [PAGES-1:0] miss, held;
  logic [2:0]       cur_col;
  logic [3:0]       cur_dig;
  logic             cur_err;
  logic [GW-1:0]    grp_q;
  logic             wr_commit;
  logic             hdr_take;

  pgreq_store #(.SLOTS(SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .ptr_load(req_ptr_load), .ptr_slot(req_ptr_slot),
    .ptr_col(req_ptr_col), .wr_en(req_wr_en), .wr_data(req_wr_data),
    .req_q(req_q), .wr_commit(wr_commit)
  );

  for (genvar p = 0; p < PAGES; p++) begin : g_grp
    assign grp_req[p] = req_q[{grp_q, PW'(p)}];
  end

  pgreq_cmp #(.PAGES(PAGES)) u_cmp (
    .grp_req(grp_req), .col(cur_col), .dig(cur_dig), .dig_err(cur_err),
    .miss(miss), .held(held)
  );

  pgreq_seq #(.PAGES(PAGES), .GROUPS(GROUPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_group(acq_group),
    .hdr_mag(hdr_mag), .hdr_mag_err(hdr_mag_err), .hdr_nibs(hdr_nibs), .hdr_errs(hdr_errs),
    .miss(miss), .held(held), .cur_col(cur_col), .cur_dig(cur_dig), .cur_err(cur_err),
    .grp_q(grp_q), .hdr_take(hdr_take), .busy(busy), .match(match),
    .match_slot(match_slot), .r25_we(r25_we), .r25_slot(r25_slot), .r25_col(r25_col),
    .r25_data(r25_data)
  );
endmodule

// File: rtl/pgreq_chk.sv
module pgreq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hdr_take,
  input logic       busy,
  input logic       match,
  input logic [2:0] match_slot,
  input logic       r25_we,
  input logic [2:0] r25_slot,
  input logic [3:0] r25_col,
  input logic [7:0] r25_data
);
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) match |=> !match); // R7
  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) hdr_take |=> busy); // R7
  AST_REC_START: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> r25_we && r25_col == 4'd0 && r25_slot == match_slot); // R9
  AST_REC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    r25_we && !match |-> $past(r25_we) && r25_col == $past(r25_col) + 4'd1 && $stable(r25_slot)); // R9
  AST_REC_RANGE: assert property (@(posedge clk) disable iff (!rst_n) r25_we |-> r25_col <= 4'd9); // R9
  AST_NIB_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    r25_we && r25_col < 4'd8 |-> r25_data[7:5] == 3'b000); // R10
  AST_FOUND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    r25_we && r25_col == 4'd8 |-> r25_data[7:3] == 5'b00000); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !match && !r25_we); // R12
endmodule

bind page_req_match pgreq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_take(hdr_take), .busy(busy), .match(match),
  .match_slot(match_slot), .r25_we(r25_we), .r25_slot(r25_slot), .r25_col(r25_col),
  .r25_data(r25_data)
);

// File: tb/page_req_match_bench.sv
module page_req_match_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_ptr_load = 0, req_wr_en = 0, acq_group = 0, hdr_valid = 0, hdr_mag_err = 0;
  logic [2:0] req_ptr_slot = 0, req_ptr_col = 0, hdr_mag = 0;
  logic [4:0] req_wr_data = 0;
  logic [31:0] hdr_nibs = 0;
  logic [7:0] hdr_errs = 0;
  logic busy, match, r25_we;
  logic [2:0] match_slot, r25_slot;
  logic [3:0] r25_col;
  logic [7:0] r25_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_req_match u_page_req_match (
    .clk(clk), .rst_n(rst_n), .req_ptr_load(req_ptr_load), .req_ptr_slot(req_ptr_slot),
    .req_ptr_col(req_ptr_col), .req_wr_en(req_wr_en), .req_wr_data(req_wr_data),
    .acq_group(acq_group), .hdr_valid(hdr_valid), .hdr_mag(hdr_mag),
    .hdr_mag_err(hdr_mag_err), .hdr_nibs(hdr_nibs), .hdr_errs(hdr_errs), .busy(busy),
    .match(match), .match_slot(match_slot), .r25_we(r25_we), .r25_slot(r25_slot),
    .r25_col(r25_col), .r25_data(r25_data)
  );

  int n_tests = 0, n_fail = 0;
  logic [4:0] mdl [8][7];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench view of the request table
  function automatic int exp_slot(input int grp, input logic [2:0] mag, input logic merr,
                                  input logic [31:0] nb, input logic [7:0] er);
    logic [3:0] d [7];
    logic e [7];
    int w [7];
    d[0] = {1'b0, mag}; e[0] = merr;  w[0] = 3;
    d[1] = nb[7:4];     e[1] = er[1]; w[1] = 4;
    d[2] = nb[3:0];     e[2] = er[0]; w[2] = 4;
    d[3] = nb[23:20];   e[3] = er[5]; w[3] = 2;
    d[4] = nb[19:16];   e[4] = er[4]; w[4] = 4;
    d[5] = nb[15:12];   e[5] = er[3]; w[5] = 3;
    d[6] = nb[11:8];    e[6] = er[2]; w[6] = 4;
    for (int p = 0; p < 4; p++) begin
      int s = grp * 4 + p;
      bit ok = mdl[s][0][3];
      for (int c = 0; c < 7; c++)
        if (mdl[s][c][4]) begin
          if (e[c]) ok = 0;
          for (int b = 0; b < w[c]; b++)
            if (mdl[s][c][b] != d[c][b]) ok = 0;
        end
      if (ok) return s;
    end
    return -1;
  endfunction

  function automatic logic [7:0] exp_byte(input int k, input logic [31:0] nb,
                                          input logic [7:0] er, input logic [2:0] mag);
    if (k < 8) return {3'b000, er[k], nb[k*4 +: 4]};
    if (k == 8) return {5'b00000, mag};
    return 8'h00;
  endfunction

  task automatic write_req(input int slot, input int start, input int count,
                           input logic [4:0] v [7]);
    int c = start;
    @(negedge clk);
    req_ptr_load = 1; req_ptr_slot = 3'(slot); req_ptr_col = 3'(start);
    @(negedge clk);
    req_ptr_load = 0;
    for (int i = 0; i < count; i++) begin
      req_wr_en = 1; req_wr_data = v[i];
      if (c < 7) mdl[slot][c] = v[i];
      c = (c + 1) % 8;
      @(negedge clk);
    end
    req_wr_en = 0;
  endtask

  task automatic run_hdr(input int grp, input logic [2:0] mag, input logic merr,
                         input logic [31:0] nb, input logic [7:0] er, input bit inject,
                         input string tag);
    int e = exp_slot(grp, mag, merr, nb, er);
    @(negedge clk);
    acq_group = grp[0]; hdr_valid = 1; hdr_mag = mag; hdr_mag_err = merr;
    hdr_nibs = nb; hdr_errs = er;
    @(negedge clk);
    hdr_valid = 0;
    chk(busy === 1'b1, "R7 busy after header", int'(busy), 1);
    for (int c = 1; c < 8; c++) begin
      if (inject && c == 2) begin
        hdr_valid = 1; hdr_mag = ~mag; hdr_nibs = ~nb; hdr_errs = 8'h00; acq_group = ~grp[0];
      end
      @(negedge clk);
      hdr_valid = 0;
      chk(match === 1'b0, "R7 early match", int'(match), 0);
    end
    @(negedge clk);
    chk(match === (e >= 0), tag, int'(match), int'(e >= 0));
    if (e >= 0) begin
      chk(match_slot === 3'(e), {tag, " slot"}, int'(match_slot), e);
      for (int k = 0; k < 10; k++) begin
        chk(r25_we === 1'b1 && r25_col === 4'(k) && r25_slot === 3'(e), "R9 record stream",
            int'(r25_col), k);
        chk(r25_data === exp_byte(k, nb, er, mag), (k < 8) ? "R10 record byte" : "R11 record byte",
            int'(r25_data), int'(exp_byte(k, nb, er, mag)));
        @(negedge clk);
        chk(match === 1'b0, "R7 pulse width", int'(match), 0);
      end
    end
    chk(busy === 1'b0 && r25_we === 1'b0, "R12 idle after header", int'(busy), 0);
  endtask

  function automatic logic [31:0] hdr_from(input int s, input logic [31:0] nb);
    logic [31:0] h = nb;
    h[7:4]   = mdl[s][1][3:0];
    h[3:0]   = mdl[s][2][3:0];
    h[21:20] = mdl[s][3][1:0];
    h[19:16] = mdl[s][4][3:0];
    h[14:12] = mdl[s][5][2:0];
    h[11:8]  = mdl[s][6][3:0];
    return h;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] v [7];
    logic [31:0] nb;
    void'($urandom(32'd4711));
    for (int s = 0; s < 8; s++) for (int c = 0; c < 7; c++) mdl[s][c] = 5'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && match === 0 && r25_we === 0, "R1 reset idle", int'(busy), 0);
    run_hdr(0, 3'd0, 0, 32'h0, 8'h0, 0, "R1 cleared table no match");
    run_hdr(1, 3'd5, 0, 32'h12345678, 8'h0, 0, "R1 cleared table no match");

    // slot 1: magazine 3, page 25, time wildcarded
    v = '{5'b11011, 5'b10010, 5'b10101, 5'b00011, 5'b01111, 5'b00111, 5'b01001};
    write_req(1, 0, 7, v);
    nb = 32'h9A_3C_7E_25;
    run_hdr(0, 3'd3, 0, nb, 8'h00, 0, "R3 cared digits equal");
    run_hdr(0, 3'd3, 0, {nb[31:4], 4'h6}, 8'h00, 0, "R3 page units differ");
    run_hdr(0, 3'd3, 0, nb ^ 32'hFFF0_FF00, 8'h00, 0, "R3 uncared digits differ");
    run_hdr(0, 3'd3, 0, nb, 8'h01, 0, "R5 error on cared digit");
    run_hdr(0, 3'd3, 0, nb, 8'hF0, 0, "R5 error on uncared digit");
    run_hdr(0, 3'd3, 1, nb, 8'h00, 0, "R5 magazine error");

    v[0] = 5'b10011;
    write_req(1, 0, 1, v);
    run_hdr(0, 3'd3, 0, nb, 8'h00, 0, "R4 held slot");
    v[0] = 5'b11011;
    write_req(1, 0, 1, v);

    v[0] = 5'b10010; v[1] = 5'b10111;
    write_req(1, 3, 2, v);
    run_hdr(0, 3'd3, 0, {8'h02, 4'h7, nb[15:0]} , 8'h00, 0, "R2 partial write match");
    run_hdr(0, 3'd3, 0, {8'h01, 4'h7, nb[15:0]} , 8'h00, 0, "R2 partial write mismatch");
    v[0] = 5'b00000; v[1] = 5'b00000;
    write_req(1, 7, 2, v);
    run_hdr(0, 3'd3, 0, {8'h02, 4'h7, nb[15:0]} , 8'h00, 0, "R2 column 7 discarded then wrap");

    v = '{5'b11100, 5'b0, 5'b0, 5'b0, 5'b0, 5'b0, 5'b0};
    write_req(6, 0, 7, v);
    run_hdr(0, 3'd4, 0, nb, 8'h00, 0, "R6 other group idle");
    run_hdr(1, 3'd4, 0, nb, 8'h00, 0, "R6 active group match");
    write_req(4, 0, 7, v);
    run_hdr(1, 3'd4, 0, nb, 8'h00, 0, "R8 lowest page wins");
    run_hdr(1, 3'd4, 0, nb, 8'h00, 1, "R7 header while busy ignored");

    for (int it = 0; it < 400; it++) begin
      int g, s;
      logic [2:0] mag;
      logic merr;
      logic [7:0] er;
      if ($urandom_range(0, 9) < 3) begin
        for (int c = 0; c < 7; c++) v[c] = 5'($urandom);
        if ($urandom_range(0, 9) < 8) v[0][3] = 1'b1;
        write_req($urandom_range(0, 7), 0, 7, v);
      end
      g = $urandom_range(0, 1);
      s = g * 4 + $urandom_range(0, 3);
      nb = 32'($urandom);
      mag = 3'($urandom);
      if ($urandom_range(0, 9) < 7) begin
        nb = hdr_from(s, nb);
        mag = mdl[s][0][2:0];
        if ($urandom_range(0, 3) == 0) nb[4 * $urandom_range(0, 7) +: 4] ^= 4'($urandom);
      end
      er = 8'h00;
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 9) == 0) er[b] = 1'b1;
      merr = ($urandom_range(0, 9) == 0);
      run_hdr(g, mag, merr, nb, er, $urandom_range(0, 9) == 0, "R3 random match result");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule